// File: doc/BRIEF.md
# Transmit Descriptor Ring Tracker

This block tracks which slots of a circular ring of transmit buffer descriptors the host owns and which the transmit engine owns. The descriptor storage sits inside the block as a register array. The host submits a frame by naming a length and a buffer address. The block writes them into the descriptor at the producer index, wipes the old completion status and raises four control flags at once: ready, interrupt-on-done, last-in-frame and append-CRC. The transmit engine reads descriptors through its own port. When it has sent a frame it clears the ready flag and leaves a completion status word.

The host drains finished descriptors through a reclaim port, one per cycle and strictly in ring order. For each one the port reports the slot and its status, and the block updates three frame counters: good frames, errored frames and frames that saw deferral.

An empty ring and a full ring both leave the producer and consumer indices equal. A three-state controller tells the two cases apart:

- **RING_EMPTY**: nothing is outstanding.
- **RING_PART**: some slots are outstanding.
- **RING_FULL**: every slot is outstanding.

The controller moves between these states as follows:

- **SUBMIT_FIRST** goes from RING_EMPTY to RING_PART.
- **SUBMIT_FILL** goes from RING_PART to RING_FULL.
- **RECLAIM_LAST** goes from RING_PART to RING_EMPTY.
- **RECLAIM_FROM_FULL** goes from RING_FULL to RING_PART.
- Any other cycle holds the state.

Top module: `tdr_ring_tracker`

## Requirements
- R1: The ring has DEPTH slots (16 by default). Only the last slot carries a wrap mark, and both indices step from slot DEPTH-1 back to slot 0.
- R2: A submit is refused while the ring is RING_FULL or while the slot at the producer index still has its ready flag set. When refused, sub_busy=1, sub_acc=0, and neither the slot nor the producer index changes.
- R3: An accepted submit (sub_acc=1) stores sub_len and sub_addr and zeroes the slot's status. It sets eng_ctl to 4'b1111, with bit 0 ready, bit 1 interrupt-on-done, bit 2 last-in-frame and bit 3 append-CRC. The producer index then advances by one slot.
- R4: When an accepted submit moves the producer onto the consumer index, ring_full=1 and prod_idx==cons_idx. ring_empty=1 exactly when the indices are equal and the ring is not full. ring_full and ring_empty are never both high.
- R5: A reclaim request succeeds (rec_valid=1) only if the ring is not empty and the slot at the consumer index has its ready flag clear. A ready slot at the consumer blocks reclaim even if later slots are finished.
- R6: A successful reclaim reports rec_idx equal to the consumer index and rec_stat equal to the slot's stored status, then advances the consumer index. Reclaim stops once the consumer reaches the producer.
- R7: The status bits are: bit 0 no heartbeat, bit 1 late collision, bit 2 retry limit, bit 3 underrun, bit 4 carrier lost. A reclaimed slot with any of these bits set adds one to err_cnt. Otherwise it adds one to good_cnt.
- R8: Status bit 5 (deferred) adds one to coll_cnt on reclaim, independently of the error/good decision.
- R9: A successful reclaim while RING_FULL clears ring_full at the same clock edge.
- R10: A synchronous reset zeroes both indices, all control flags and all counters, and enters RING_EMPTY.
- R11: eng_done on the slot named by eng_idx clears that slot's ready flag and stores eng_stat. If the slot's ready flag is already clear, the completion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sub_req | input | 1 | Host submit request |
| sub_len | input | LEN_W | Frame length to store |
| sub_addr | input | ADDR_W | Buffer address to store |
| sub_acc | output | 1 | Submit accepted this cycle |
| sub_busy | output | 1 | Submit refused this cycle |
| eng_done | input | 1 | Engine completion strobe |
| eng_idx | input | IDX_W | Slot the engine reads or completes |
| eng_stat | input | 6 | Completion status to store |
| eng_len | output | LEN_W | Length of slot eng_idx |
| eng_addr | output | ADDR_W | Address of slot eng_idx |
| eng_ctl | output | 4 | Control flags of slot eng_idx |
| eng_cur_stat | output | 6 | Stored status of slot eng_idx |
| rec_req | input | 1 | Host reclaim request |
| rec_valid | output | 1 | A slot is reclaimed this cycle |
| rec_idx | output | IDX_W | Slot being reclaimed |
| rec_stat | output | 6 | Status of the reclaimed slot |
| prod_idx | output | IDX_W | Producer index |
| cons_idx | output | IDX_W | Consumer index |
| ring_full | output | 1 | Every slot outstanding |
| ring_empty | output | 1 | No slot outstanding |
| err_cnt | output | CNT_W | Errored frame count |
| good_cnt | output | CNT_W | Good frame count |
| coll_cnt | output | CNT_W | Deferred frame count |

## Verification
The bench keeps the default parameters: DEPTH=16, LEN_W=11, ADDR_W=16 and CNT_W=16. Sixteen slots are enough to fill the ring completely, to force both indices through the wrap from slot 15 to slot 0, and to reach RING_FULL with the indices parked at a non-zero slot. With those sizes the bench can also create a full ring whose consumer slot is already finished, which separates the full-flag refusal from the ready-flag refusal.

// File: rtl/tdr_pkg.sv
`timescale 1ns/1ps
package tdr_pkg;

    typedef enum logic [1:0] {
        RING_EMPTY = 2'd0,
        RING_PART  = 2'd1,
        RING_FULL  = 2'd2
    } ring_state_e;

    // completion status word layout
    localparam int STAT_W    = 6;
    localparam int ST_NOHB   = 0;
    localparam int ST_LATE   = 1;
    localparam int ST_RETRY  = 2;
    localparam int ST_UNDER  = 3;
    localparam int ST_NOCARR = 4;
    localparam int ST_DEFER  = 5;
    localparam logic [STAT_W-1:0] ERR_MASK = 6'b01_1111;

    // per-slot control flags
    localparam int CTL_W     = 4;
    localparam int CTL_READY = 0;
    localparam int CTL_IRQ   = 1;
    localparam int CTL_LAST  = 2;
    localparam int CTL_CRC   = 3;

endpackage

// File: rtl/tdr_desc_array.sv
`timescale 1ns/1ps
module tdr_desc_array
    import tdr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 11,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              done_en,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic [STAT_W-1:0] done_stat,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [LEN_W-1:0]  rda_len,
    output logic [ADDR_W-1:0] rda_addr,
    output logic [CTL_W-1:0]  rda_ctl,
    output logic [STAT_W-1:0] rda_stat,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [STAT_W-1:0] rdb_stat,
    output logic [DEPTH-1:0]  ready_vec,
    output logic [DEPTH-1:0]  wrap_vec
);

    logic [LEN_W-1:0]  len_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [CTL_W-1:0]  ctl_q  [DEPTH];
    logic [STAT_W-1:0] stat_q [DEPTH];

    // only the final slot carries the wrap mark
    for (genvar g = 0; g < DEPTH; g++) begin : g_wrap
        assign wrap_vec[g] = (g == DEPTH - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                len_q[i]  <= '0;
                addr_q[i] <= '0;
                ctl_q[i]  <= '0;
                stat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    len_q[i]  <= wr_len;
                    addr_q[i] <= wr_addr;
                    stat_q[i] <= '0;
                    ctl_q[i]  <= '1;
                end else if (done_en && done_idx == IDX_W'(i) && ctl_q[i][CTL_READY]) begin
                    ctl_q[i][CTL_READY] <= 1'b0;
                    stat_q[i]           <= done_stat;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ready_vec[i] = ctl_q[i][CTL_READY];
        end
    end

    assign rda_len  = len_q[rda_idx];
    assign rda_addr = addr_q[rda_idx];
    assign rda_ctl  = ctl_q[rda_idx];
    assign rda_stat = stat_q[rda_idx];
    assign rdb_stat = stat_q[rdb_idx];

endmodule

// File: rtl/tdr_ring_ctrl.sv
`timescale 1ns/1ps
module tdr_ring_ctrl
    import tdr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sub_req,
    input  logic             rec_req,
    input  logic [DEPTH-1:0] ready_vec,
    input  logic [DEPTH-1:0] wrap_vec,
    output logic [IDX_W-1:0] prod_q,
    output logic [IDX_W-1:0] cons_q,
    output ring_state_e      state_q,
    output logic             sub_acc,
    output logic             sub_busy,
    output logic             rec_valid
);

    ring_state_e      state_nx;
    logic [IDX_W-1:0] prod_nx;
    logic [IDX_W-1:0] cons_nx;
    logic             blocked;

    // state register and indices
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RING_EMPTY;
            prod_q  <= '0;
            cons_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (sub_acc)   prod_q <= prod_nx;
            if (rec_valid) cons_q <= cons_nx;
        end
    end

    // handshakes and next state
    always_comb begin
        prod_nx   = wrap_vec[prod_q] ? '0 : prod_q + 1'b1;
        cons_nx   = wrap_vec[cons_q] ? '0 : cons_q + 1'b1;
        blocked   = (state_q == RING_FULL) || ready_vec[prod_q];
        sub_acc   = sub_req && !blocked;
        sub_busy  = sub_req && blocked;
        rec_valid = rec_req && (state_q != RING_EMPTY) && !ready_vec[cons_q];
        state_nx  = state_q;
        unique case (state_q)
            RING_EMPTY: begin
                if (sub_acc) state_nx = (prod_nx == cons_q) ? RING_FULL : RING_PART;
            end
            RING_PART: begin
                if (sub_acc && !rec_valid && prod_nx == cons_q)
                    state_nx = RING_FULL;
                else if (rec_valid && !sub_acc && cons_nx == prod_q)
                    state_nx = RING_EMPTY;
            end
            RING_FULL: begin
                if (rec_valid) state_nx = (cons_nx == prod_q) ? RING_EMPTY : RING_PART;
            end
            default: state_nx = RING_EMPTY;
        endcase
    end

endmodule

// File: rtl/tdr_frame_stats.sv
`timescale 1ns/1ps
module tdr_frame_stats
    import tdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [STAT_W-1:0] stat,
    output logic [CNT_W-1:0]  err_q,
    output logic [CNT_W-1:0]  good_q,
    output logic [CNT_W-1:0]  coll_q
);

    logic is_err;

    always_comb is_err = |(stat & ERR_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            good_q <= '0;
            coll_q <= '0;
        end else if (hit) begin
            if (is_err) err_q  <= err_q + 1'b1;
            else        good_q <= good_q + 1'b1;
            if (stat[ST_DEFER]) coll_q <= coll_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdr_ring_tracker.sv
`timescale 1ns/1ps
module tdr_ring_tracker
    import tdr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 11,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_req,
    input  logic [LEN_W-1:0]  sub_len,
    input  logic [ADDR_W-1:0] sub_addr,
    output logic              sub_acc,
    output logic              sub_busy,
    input  logic              eng_done,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [5:0]        eng_stat,
    output logic [LEN_W-1:0]  eng_len,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [3:0]        eng_ctl,
    output logic [5:0]        eng_cur_stat,
    input  logic              rec_req,
    output logic              rec_valid,
    output logic [IDX_W-1:0]  rec_idx,
    output logic [5:0]        rec_stat,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              ring_full,
    output logic              ring_empty,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [CNT_W-1:0]  good_cnt,
    output logic [CNT_W-1:0]  coll_cnt
);

    logic [DEPTH-1:0] ready_vec;
    logic [DEPTH-1:0] wrap_vec;
    ring_state_e      ring_st;

    tdr_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sub_req   (sub_req),
        .rec_req   (rec_req),
        .ready_vec (ready_vec),
        .wrap_vec  (wrap_vec),
        .prod_q    (prod_idx),
        .cons_q    (cons_idx),
        .state_q   (ring_st),
        .sub_acc   (sub_acc),
        .sub_busy  (sub_busy),
        .rec_valid (rec_valid)
    );

    tdr_desc_array #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_desc (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sub_acc),
        .wr_idx    (prod_idx),
        .wr_len    (sub_len),
        .wr_addr   (sub_addr),
        .done_en   (eng_done),
        .done_idx  (eng_idx),
        .done_stat (eng_stat),
        .rda_idx   (eng_idx),
        .rda_len   (eng_len),
        .rda_addr  (eng_addr),
        .rda_ctl   (eng_ctl),
        .rda_stat  (eng_cur_stat),
        .rdb_idx   (cons_idx),
        .rdb_stat  (rec_stat),
        .ready_vec (ready_vec),
        .wrap_vec  (wrap_vec)
    );

    tdr_frame_stats #(.CNT_W(CNT_W)) u_stats (
        .clk    (clk),
        .rst    (rst),
        .hit    (rec_valid),
        .stat   (rec_stat),
        .err_q  (err_cnt),
        .good_q (good_cnt),
        .coll_q (coll_cnt)
    );

    assign rec_idx    = cons_idx;
    assign ring_full  = (ring_st == RING_FULL);
    assign ring_empty = (ring_st == RING_EMPTY);

endmodule

// File: rtl/tdr_ring_checker.sv
`timescale 1ns/1ps
module tdr_ring_checker
    import tdr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             sub_req,
    input logic             sub_acc,
    input logic             sub_busy,
    input logic             rec_valid,
    input logic [5:0]       rec_stat,
    input logic [IDX_W-1:0] prod_idx,
    input logic [IDX_W-1:0] cons_idx,
    input logic             ring_full,
    input logic             ring_empty,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] coll_cnt
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

    // R4
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ring_full && ring_empty));

    // R4
    full_idx_equal_chk: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> (prod_idx == cons_idx));

    // R2
    full_refuses_chk: assert property (@(posedge clk) disable iff (rst)
        (ring_full && sub_req) |-> (sub_busy && !sub_acc));

    // R1
    prod_step_chk: assert property (@(posedge clk) disable iff (rst)
        sub_acc |=> (prod_idx == (($past(prod_idx) == LAST_SLOT) ? '0 : $past(prod_idx) + 1'b1)));

    // R6
    cons_step_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> (cons_idx == (($past(cons_idx) == LAST_SLOT) ? '0 : $past(cons_idx) + 1'b1)));

    // R5
    empty_no_reclaim_chk: assert property (@(posedge clk) disable iff (rst)
        ring_empty |-> !rec_valid);

    // R9
    full_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ring_full && rec_valid) |=> !ring_full);

    // R7
    err_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && |(rec_stat & ERR_MASK)) |=> (err_cnt == $past(err_cnt) + 1'b1));

    // R8
    coll_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_stat[ST_DEFER]) |=> (coll_cnt == $past(coll_cnt) + 1'b1));

endmodule

bind tdr_ring_tracker tdr_ring_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sub_req    (sub_req),
    .sub_acc    (sub_acc),
    .sub_busy   (sub_busy),
    .rec_valid  (rec_valid),
    .rec_stat   (rec_stat),
    .prod_idx   (prod_idx),
    .cons_idx   (cons_idx),
    .ring_full  (ring_full),
    .ring_empty (ring_empty),
    .err_cnt    (err_cnt),
    .coll_cnt   (coll_cnt)
);

// File: tb/test_tdr_ring_tracker.sv
`timescale 1ns/1ps
module test_tdr_ring_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_req = 1'b0;
    logic [10:0] sub_len = '0;
    logic [15:0] sub_addr = '0;
    logic        sub_acc, sub_busy;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_idx = '0;
    logic [5:0]  eng_stat = '0;
    logic [10:0] eng_len;
    logic [15:0] eng_addr;
    logic [3:0]  eng_ctl;
    logic [5:0]  eng_cur_stat;
    logic        rec_req = 1'b0;
    logic        rec_valid;
    logic [3:0]  rec_idx;
    logic [5:0]  rec_stat;
    logic [3:0]  prod_idx, cons_idx;
    logic        ring_full, ring_empty;
    logic [15:0] err_cnt, good_cnt, coll_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_err = 0, exp_good = 0, exp_coll = 0;

    always #5 clk = ~clk;

    tdr_ring_tracker i_tdr_ring_tracker (
        .clk(clk), .rst(rst),
        .sub_req(sub_req), .sub_len(sub_len), .sub_addr(sub_addr),
        .sub_acc(sub_acc), .sub_busy(sub_busy),
        .eng_done(eng_done), .eng_idx(eng_idx), .eng_stat(eng_stat),
        .eng_len(eng_len), .eng_addr(eng_addr), .eng_ctl(eng_ctl), .eng_cur_stat(eng_cur_stat),
        .rec_req(rec_req), .rec_valid(rec_valid), .rec_idx(rec_idx), .rec_stat(rec_stat),
        .prod_idx(prod_idx), .cons_idx(cons_idx),
        .ring_full(ring_full), .ring_empty(ring_empty),
        .err_cnt(err_cnt), .good_cnt(good_cnt), .coll_cnt(coll_cnt)
    );

    // {status[5:0], err_inc, good_inc, coll_inc}
    localparam logic [8:0] VEC_TAB [8] = '{
        {6'b000000, 3'b010},
        {6'b000001, 3'b100},
        {6'b000010, 3'b100},
        {6'b000100, 3'b100},
        {6'b001000, 3'b100},
        {6'b010000, 3'b100},
        {6'b100000, 3'b011},
        {6'b100010, 3'b101}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_submit(input logic [10:0] l, input logic [15:0] a,
                             output logic acc, output logic busy);
        @(negedge clk);
        sub_req = 1'b1; sub_len = l; sub_addr = a;
        #1; acc = sub_acc; busy = sub_busy;
        @(posedge clk); #1;
        sub_req = 1'b0;
    endtask

    task automatic do_complete(input logic [3:0] idx, input logic [5:0] st);
        @(negedge clk);
        eng_done = 1'b1; eng_idx = idx; eng_stat = st;
        @(posedge clk); #1;
        eng_done = 1'b0;
    endtask

    task automatic do_reclaim(output logic v, output logic [3:0] idx, output logic [5:0] st);
        @(negedge clk);
        rec_req = 1'b1;
        #1; v = rec_valid; idx = rec_idx; st = rec_stat;
        @(posedge clk); #1;
        rec_req = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx);
        eng_idx = idx; #1;
    endtask

    task automatic check_counts(input string req);
        chk(req, "err_cnt", int'(err_cnt), exp_err);
        chk(req, "good_cnt", int'(good_cnt), exp_good);
        chk(req, "coll_cnt", int'(coll_cnt), exp_coll);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic acc, busy, v;
        logic [3:0] ri;
        logic [5:0] rs;
        logic [3:0] slot;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10", "ring_empty", int'(ring_empty), 1);
        chk("R10", "ring_full", int'(ring_full), 0);
        chk("R10", "prod_idx", int'(prod_idx), 0);
        chk("R10", "cons_idx", int'(cons_idx), 0);
        check_counts("R10");

        // R3 submit writes the slot
        do_submit(11'd100, 16'h1000, acc, busy);
        chk("R3", "sub_acc", int'(acc), 1);
        chk("R3", "sub_busy", int'(busy), 0);
        chk("R3", "prod_idx", int'(prod_idx), 1);
        chk("R4", "ring_empty", int'(ring_empty), 0);
        peek(4'd0);
        chk("R3", "eng_len", int'(eng_len), 100);
        chk("R3", "eng_addr", int'(eng_addr), 16'h1000);
        chk("R3", "eng_ctl", int'(eng_ctl), 4'hF);
        chk("R3", "eng_cur_stat", int'(eng_cur_stat), 0);

        // R5 ready slot blocks reclaim
        do_reclaim(v, ri, rs);
        chk("R5", "rec_valid while ready", int'(v), 0);
        chk("R5", "cons_idx", int'(cons_idx), 0);

        // R11 completion clears ready
        do_complete(4'd0, 6'b000000);
        peek(4'd0);
        chk("R11", "eng_ctl after done", int'(eng_ctl), 4'hE);

        // R6 reclaim
        do_reclaim(v, ri, rs);
        chk("R6", "rec_valid", int'(v), 1);
        chk("R6", "rec_idx", int'(ri), 0);
        exp_good++;
        check_counts("R7");
        chk("R4", "ring_empty after drain", int'(ring_empty), 1);

        // R6 reclaim stops at producer
        do_reclaim(v, ri, rs);
        chk("R6", "rec_valid on empty", int'(v), 0);

        // R11 completion on a non-ready slot is ignored
        do_complete(4'd0, 6'h3F);
        peek(4'd0);
        chk("R11", "eng_cur_stat ignored", int'(eng_cur_stat), 0);
        chk("R11", "eng_ctl ignored", int'(eng_ctl), 4'hE);
        check_counts("R11");

        // R7 R8 status table
        for (int k = 0; k < 8; k++) begin
            slot = prod_idx;
            do_submit(11'(200 + k), 16'(16'h2000 + k), acc, busy);
            chk("R3", "table submit", int'(acc), 1);
            do_complete(slot, VEC_TAB[k][8:3]);
            do_reclaim(v, ri, rs);
            chk("R6", "table rec_valid", int'(v), 1);
            chk("R6", "table rec_idx", int'(ri), int'(slot));
            chk("R6", "table rec_stat", int'(rs), int'(VEC_TAB[k][8:3]));
            exp_err  += int'(VEC_TAB[k][2]);
            exp_good += int'(VEC_TAB[k][1]);
            exp_coll += int'(VEC_TAB[k][0]);
            check_counts("R7 R8");
        end
        chk("R1", "prod after table", int'(prod_idx), 9);

        // R4 R1 fill ring from slot 9
        for (int k = 0; k < 16; k++) begin
            do_submit(11'(300 + k), 16'(16'h3000 + k), acc, busy);
            chk("R4", "fill submit", int'(acc), 1);
            if (k == 6) chk("R1", "prod wraps to 0", int'(prod_idx), 0);
            if (k == 14) chk("R4", "not yet full", int'(ring_full), 0);
        end
        chk("R4", "ring_full", int'(ring_full), 1);
        chk("R4", "ring_empty when full", int'(ring_empty), 0);
        chk("R4", "prod_idx", int'(prod_idx), 9);
        chk("R4", "cons_idx", int'(cons_idx), 9);

        // R2 submit while full
        do_submit(11'd7, 16'h7777, acc, busy);
        chk("R2", "sub_busy full", int'(busy), 1);
        chk("R2", "sub_acc full", int'(acc), 0);
        chk("R2", "prod held", int'(prod_idx), 9);

        // R5 in-order reclaim
        do_complete(4'd10, 6'b000000);
        do_reclaim(v, ri, rs);
        chk("R5", "out of order reclaim", int'(v), 0);

        // R2 full ring with finished producer slot still refuses
        do_complete(4'd9, 6'b000000);
        do_submit(11'd8, 16'h8888, acc, busy);
        chk("R2", "busy on full finished slot", int'(busy), 1);
        peek(4'd9);
        chk("R2", "slot 9 untouched", int'(eng_ctl), 4'hE);

        // R9 reclaim clears full
        do_reclaim(v, ri, rs);
        chk("R9", "rec_valid", int'(v), 1);
        chk("R9", "rec_idx", int'(ri), 9);
        chk("R9", "ring_full cleared", int'(ring_full), 0);
        exp_good++;

        do_submit(11'd9, 16'h9999, acc, busy);
        chk("R4", "refill accepted", int'(acc), 1);
        chk("R4", "full again", int'(ring_full), 1);

        // drain everything
        for (int k = 0; k < 16; k++) do_complete(4'(k), 6'b000000);
        for (int k = 0; k < 16; k++) begin
            do_reclaim(v, ri, rs);
            chk("R6", "drain rec_valid", int'(v), 1);
            chk("R6", "drain rec_idx", int'(ri), (10 + k) % 16);
        end
        exp_good += 16;
        check_counts("R7");
        chk("R4", "empty after drain", int'(ring_empty), 1);
        do_reclaim(v, ri, rs);
        chk("R6", "reclaim past producer", int'(v), 0);

        // R10 mid-run reset
        do_submit(11'd5, 16'h5555, acc, busy);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        exp_err = 0; exp_good = 0; exp_coll = 0;
        peek(4'd10);
        chk("R10", "ring_empty", int'(ring_empty), 1);
        chk("R10", "prod_idx", int'(prod_idx), 0);
        chk("R10", "cons_idx", int'(cons_idx), 0);
        chk("R10", "eng_ctl cleared", int'(eng_ctl), 0);
        check_counts("R10");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule